// File: doc/BRIEF.md
# Parallel port ownership multiplexer

This block hands one shared set of parallel-port pins (an 8-bit bidirectional data bus, a group of control outputs and a group of status inputs) to one of three owners. The first owner is an on-chip microcontroller that drives the port directly through four byte-wide registers. The second is a floppy disk controller that reuses the pins as a drive interface. The third is the host's legacy parallel port engine. The two protocol engines are outside this block and appear only as abstract data, enable, powerdown and fan-back ports.

A hardware-assist bit and two configuration bits choose the owner. The owner code and every pin output enable are registered on the system clock, so the enables never glitch. Each owner has its own tri-state rule. The microcontroller drives whenever power is good. The other two owners drive only while they are not powered down. A low power-good input turns every enable off for all owners.

Owners that do not hold the pins see an idle port: data reads as all ones and status lines read as zero. The 2-bit owner code is an output, so software can see which owner holds the pins.

Top module: `pport_owner_mux`

## Requirements
- R1: With `assist` = 0, `owner` becomes 0 (microcontroller) one clock later, whatever `cfg_a` and `cfg_b` hold.
- R2: With `assist` = 1 and `cfg_a` != `cfg_b`, `owner` becomes 1 (floppy controller) one clock later.
- R3: With `assist` = 1 and `cfg_a` == `cfg_b`, `owner` becomes 2 (host port) one clock later. Code 3 never appears.
- R4: `owner`, `pin_data_oe` and `pin_ctl_oe` change only on a rising clock edge. A configuration change shows up after the next edge and not before it.
- R5: Under microcontroller ownership, `pin_data_o` equals the data register and `pin_ctl_o` equals the control register. Bit i of `pin_data_oe` is 1 when bit i of the direction register is 0, and `pin_ctl_oe` is 1. All of these hold while `pgood` is 1.
- R6: Under floppy or host ownership, the pins carry that owner's data and control. `pin_data_oe` is all ones when the owner's data enable is 1 and its powerdown is 0, and zero otherwise. `pin_ctl_oe` equals the inverse of that owner's powerdown.
- R7: While `pgood` is 0, `pin_data_oe` is 0 and `pin_ctl_oe` is 0 after the next clock, whatever the owner.
- R8: The selected owner's fan-back ports carry `pin_data_i` and `pin_stat_i`. An unselected owner receives data all ones and status all zeros.
- R9: Register map on `bus_addr`:
  - 0: a write loads the data register; a read returns `pin_data_i`, or all ones when the microcontroller is not owner.
  - 1: direction, read/write, where 1 means the pin is an input.
  - 2: control, read/write, with the low 4 bits used and the upper bits reading 0.
  - 3: a read returns `pin_stat_i` zero-extended, or 0 when the microcontroller is not owner; writes have no effect.
- R10: Reset (`rst_n` = 0) gives `owner` 0, all enables 0, data register 0, direction register all ones and control register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgood | input | 1 | Pin supply good; 0 forces all enables off |
| assist | input | 1 | Hardware-assist select; 0 gives the pins to the microcontroller |
| cfg_a | input | 1 | Configuration bit A |
| cfg_b | input | 1 | Configuration bit B |
| bus_addr | input | 2 | Microcontroller register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| fdc_data_o | input | 8 | Floppy controller data toward the pins |
| fdc_data_oe | input | 1 | Floppy controller data drive request |
| fdc_ctl_o | input | 4 | Floppy controller control outputs |
| fdc_pwrdn | input | 1 | Floppy controller powered down |
| fdc_data_i | output | 8 | Data fan-back to the floppy controller |
| fdc_stat_i | output | 5 | Status fan-back to the floppy controller |
| host_data_o | input | 8 | Host port data toward the pins |
| host_data_oe | input | 1 | Host port data drive request |
| host_ctl_o | input | 4 | Host port control outputs |
| host_pwrdn | input | 1 | Host port powered down |
| host_data_i | output | 8 | Data fan-back to the host port |
| host_stat_i | output | 5 | Status fan-back to the host port |
| pin_data_i | input | 8 | Live data pin levels |
| pin_data_o | output | 8 | Data pin output values |
| pin_data_oe | output | 8 | Per-bit data pin output enable |
| pin_ctl_o | output | 4 | Control pin output values |
| pin_ctl_oe | output | 1 | Control pin output enable |
| pin_stat_i | input | 5 | Live status pin levels |
| owner | output | 2 | Current owner: 0 microcontroller, 1 floppy, 2 host |

## Verification
A wrong owner register shows up on every output one clock after the configuration inputs change. `owner` changes, the pin values switch to another source, and the fan-back ports of two owners swap between live and idle values. Because of this, the owner is compared exactly one edge after each change, and also just before that edge. A stale enable register leaves the pins driven or floating for one or more extra cycles after a powerdown, a power-good loss or a direction write. The bench samples each enable in the first half-cycle after the edge that should have updated it.

// File: rtl/pport_owner_mux.sv
module pport_owner_mux #(
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgood,
  input  logic          assist,
  input  logic          cfg_a,
  input  logic          cfg_b,
  input  logic [1:0]    bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] fdc_data_o,
  input  logic          fdc_data_oe,
  input  logic [CW-1:0] fdc_ctl_o,
  input  logic          fdc_pwrdn,
  output logic [DW-1:0] fdc_data_i,
  output logic [SW-1:0] fdc_stat_i,
  input  logic [DW-1:0] host_data_o,
  input  logic          host_data_oe,
  input  logic [CW-1:0] host_ctl_o,
  input  logic          host_pwrdn,
  output logic [DW-1:0] host_data_i,
  output logic [SW-1:0] host_stat_i,
  input  logic [DW-1:0] pin_data_i,
  output logic [DW-1:0] pin_data_o,
  output logic [DW-1:0] pin_data_oe,
  output logic [CW-1:0] pin_ctl_o,
  output logic          pin_ctl_oe,
  input  logic [SW-1:0] pin_stat_i,
  output logic [1:0]    owner
);

  localparam logic [1:0] OWN_MCU  = 2'd0;
  localparam logic [1:0] OWN_FDC  = 2'd1;
  localparam logic [1:0] OWN_HOST = 2'd2;

  logic [1:0]    own_q, own_d;
  logic [DW-1:0] dat_q, dir_q, dir_nx, doe_d;
  logic [CW-1:0] ctl_q;
  logic          coe_d;

  assign own_d  = !assist ? OWN_MCU : (cfg_a ^ cfg_b) ? OWN_FDC : OWN_HOST;
  assign dir_nx = (bus_we && bus_addr == 2'd1) ? bus_wdata : dir_q;

  always_comb begin
    case (own_d)
      OWN_MCU: begin
        doe_d = ~dir_nx;
        coe_d = 1'b1;
      end
      OWN_FDC: begin
        doe_d = {DW{fdc_data_oe & ~fdc_pwrdn}};
        coe_d = ~fdc_pwrdn;
      end
      default: begin
        doe_d = {DW{host_data_oe & ~host_pwrdn}};
        coe_d = ~host_pwrdn;
      end
    endcase
    if (!pgood) begin
      doe_d = '0;
      coe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q       <= OWN_MCU;
      dat_q       <= '0;
      dir_q       <= '1;
      ctl_q       <= '0;
      pin_data_oe <= '0;
      pin_ctl_oe  <= 1'b0;
    end else begin
      own_q       <= own_d;
      dir_q       <= dir_nx;
      pin_data_oe <= doe_d;
      pin_ctl_oe  <= coe_d;
      if (bus_we && bus_addr == 2'd0) dat_q <= bus_wdata;
      if (bus_we && bus_addr == 2'd2) ctl_q <= bus_wdata[CW-1:0];
    end
  end

  always_comb begin
    case (own_q)
      OWN_MCU: begin
        pin_data_o = dat_q;
        pin_ctl_o  = ctl_q;
      end
      OWN_FDC: begin
        pin_data_o = fdc_data_o;
        pin_ctl_o  = fdc_ctl_o;
      end
      default: begin
        pin_data_o = host_data_o;
        pin_ctl_o  = host_ctl_o;
      end
    endcase
  end

  assign fdc_data_i  = (own_q == OWN_FDC)  ? pin_data_i : '1;
  assign fdc_stat_i  = (own_q == OWN_FDC)  ? pin_stat_i : '0;
  assign host_data_i = (own_q == OWN_HOST) ? pin_data_i : '1;
  assign host_stat_i = (own_q == OWN_HOST) ? pin_stat_i : '0;
  assign owner       = own_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata = (own_q == OWN_MCU) ? pin_data_i : '1;
      2'd1: bus_rdata = dir_q;
      2'd2: bus_rdata[CW-1:0] = ctl_q;
      default: if (own_q == OWN_MCU) bus_rdata[SW-1:0] = pin_stat_i;
    endcase
  end

endmodule

module pport_owner_mux_chk #(
  parameter int DW = 8,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pgood,
  input logic          assist,
  input logic          cfg_a,
  input logic          cfg_b,
  input logic [1:0]    owner,
  input logic [DW-1:0] pin_data_oe,
  input logic          pin_ctl_oe,
  input logic [DW-1:0] fdc_data_i,
  input logic [SW-1:0] fdc_stat_i,
  input logic [DW-1:0] host_data_i,
  input logic [SW-1:0] host_stat_i
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_mcu_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(assist) |-> owner == 2'd0);
  p_fdc_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(assist) && $past(cfg_a ^ cfg_b) |-> owner == 2'd1);
  p_host_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(assist) && !$past(cfg_a ^ cfg_b) |-> owner == 2'd2);
  p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    owner != 2'd3);
  p_pgood_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(pgood) |-> pin_data_oe == '0 && !pin_ctl_oe);
  p_fdc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    owner != 2'd1 |-> fdc_data_i == '1 && fdc_stat_i == '0);
  p_host_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    owner != 2'd2 |-> host_data_i == '1 && host_stat_i == '0);
endmodule

bind pport_owner_mux pport_owner_mux_chk #(.DW(DW), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pgood(pgood), .assist(assist),
  .cfg_a(cfg_a), .cfg_b(cfg_b), .owner(owner),
  .pin_data_oe(pin_data_oe), .pin_ctl_oe(pin_ctl_oe),
  .fdc_data_i(fdc_data_i), .fdc_stat_i(fdc_stat_i),
  .host_data_i(host_data_i), .host_stat_i(host_stat_i)
);

// File: tb/pport_owner_mux_tb_top.sv
`timescale 1ns/1ps
module pport_owner_mux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pgood = 1'b1, assist = 1'b0, cfg_a = 1'b0, cfg_b = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] fdc_data_o = 8'h3C, fdc_data_i, host_data_o = 8'hA5, host_data_i;
  logic       fdc_data_oe = 1'b0, fdc_pwrdn = 1'b0, host_data_oe = 1'b0, host_pwrdn = 1'b0;
  logic [3:0] fdc_ctl_o = 4'h6, host_ctl_o = 4'h9, pin_ctl_o;
  logic [4:0] fdc_stat_i, host_stat_i, pin_stat_i = 5'h15;
  logic [7:0] pin_data_i = 8'h5A, pin_data_o, pin_data_oe;
  logic       pin_ctl_oe;
  logic [1:0] owner;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pport_owner_mux dut_i (.*);

  // {assist, cfg_a, cfg_b, expected owner[1:0]}
  localparam logic [4:0] OWN_VEC [8] = '{
    5'b000_00, 5'b001_00, 5'b010_00, 5'b011_00,
    5'b100_10, 5'b101_01, 5'b110_01, 5'b111_10 };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #12;
    chk("R10 owner", owner, 0);
    chk("R10 data oe", pin_data_oe, 0);
    chk("R10 ctl oe", pin_ctl_oe, 0);
    chk("R10 data reg", pin_data_o, 0);
    rd(2'd1, "R10 dir reg", 8'hFF);
    rd(2'd2, "R10 ctl reg", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R5 ctl oe on after reset", pin_ctl_oe, 1);

    foreach (OWN_VEC[i]) begin
      {assist, cfg_a, cfg_b} = OWN_VEC[i][4:2];
      step();
      chk($sformatf("R1 R2 R3 owner vec %0d", i), owner, OWN_VEC[i][1:0]);
    end

    // R4: change visible only after the edge
    assist = 1'b0; step();
    assist = 1'b1; cfg_a = 1'b1; cfg_b = 1'b0;
    #1 chk("R4 owner held before edge", owner, 0);
    step();
    chk("R4 owner after edge", owner, 1);

    // R2/R6/R8 floppy ownership
    fdc_data_oe = 1'b1; step();
    chk("R6 fdc data", pin_data_o, 8'h3C);
    chk("R6 fdc ctl", pin_ctl_o, 4'h6);
    chk("R6 fdc data oe", pin_data_oe, 8'hFF);
    chk("R8 fdc data fanback", fdc_data_i, 8'h5A);
    chk("R8 fdc stat fanback", fdc_stat_i, 5'h15);
    chk("R8 host idle data", host_data_i, 8'hFF);
    chk("R8 host idle stat", host_stat_i, 0);
    rd(2'd0, "R9 data read idle when not owner", 8'hFF);
    rd(2'd3, "R9 stat read idle when not owner", 8'h00);
    fdc_pwrdn = 1'b1;
    #1 chk("R4 oe held before edge", pin_data_oe, 8'hFF);
    step();
    chk("R6 fdc pwrdn data oe", pin_data_oe, 0);
    chk("R6 fdc pwrdn ctl oe", pin_ctl_oe, 0);
    fdc_pwrdn = 1'b0; fdc_data_oe = 1'b0; step();
    chk("R6 fdc data oe off", pin_data_oe, 0);
    chk("R6 fdc ctl oe on", pin_ctl_oe, 1);

    // R3/R6/R8 host ownership
    cfg_b = 1'b1; host_data_oe = 1'b1; step();
    chk("R3 host owner", owner, 2);
    chk("R6 host data", pin_data_o, 8'hA5);
    chk("R6 host ctl", pin_ctl_o, 4'h9);
    chk("R6 host data oe", pin_data_oe, 8'hFF);
    chk("R8 host data fanback", host_data_i, 8'h5A);
    chk("R8 fdc idle data", fdc_data_i, 8'hFF);
    chk("R8 fdc idle stat", fdc_stat_i, 0);
    host_pwrdn = 1'b1; step();
    chk("R6 host pwrdn data oe", pin_data_oe, 0);
    chk("R6 host pwrdn ctl oe", pin_ctl_oe, 0);
    host_pwrdn = 1'b0;

    // R5/R9 microcontroller ownership
    assist = 1'b0; step();
    wr(2'd0, 8'hC3);
    wr(2'd2, 8'hFE);
    wr(2'd1, 8'h0F);
    chk("R5 data out", pin_data_o, 8'hC3);
    chk("R5 ctl out", pin_ctl_o, 4'hE);
    chk("R5 data oe from dir", pin_data_oe, 8'hF0);
    chk("R5 ctl oe", pin_ctl_oe, 1);
    rd(2'd1, "R9 dir readback", 8'h0F);
    rd(2'd2, "R9 ctl readback zero-ext", 8'h0E);
    rd(2'd0, "R9 data read live pins", 8'h5A);
    rd(2'd3, "R9 stat read live pins", 8'h15);
    pin_stat_i = 5'h0A;
    rd(2'd3, "R9 stat follows pins", 8'h0A);
    wr(2'd3, 8'hFF);
    rd(2'd1, "R9 stat write leaves dir", 8'h0F);
    rd(2'd2, "R9 stat write leaves ctl", 8'h0E);
    chk("R9 stat write leaves data", pin_data_o, 8'hC3);
    rd(2'd3, "R9 stat write no effect", 8'h0A);
    chk("R8 fdc idle under mcu", fdc_data_i, 8'hFF);

    // R7 power-good loss for each owner
    pgood = 1'b0; step();
    chk("R7 mcu data oe off", pin_data_oe, 0);
    chk("R7 mcu ctl oe off", pin_ctl_oe, 0);
    assist = 1'b1; cfg_a = 1'b0; cfg_b = 1'b1; fdc_data_oe = 1'b1; step();
    chk("R7 fdc oe off", {pin_data_oe, pin_ctl_oe}, 0);
    cfg_b = 1'b0; host_data_oe = 1'b1; step();
    chk("R7 host oe off", {pin_data_oe, pin_ctl_oe}, 0);
    pgood = 1'b1; step();
    chk("R7 host oe restored", {pin_data_oe, pin_ctl_oe}, 9'h1FF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule